// File: doc/BRIEF.md
# Clock Control Register Bank with Frequency Derivation

The block is a bank of 28 word-wide configuration registers behind a simple request/response bus slave. Each request gets a registered response one cycle later. Software reads and writes whole 32-bit words. Every register takes a fixed value when reset is asserted.

Two of the registers describe the main clock tree: the PLL control word and the clock control word. Whenever either one is written, and once after reset, a sequential engine recomputes four integer frequencies in Hz. These are the PLL output, the CPU core clock, the AHB bus clock and the IPG peripheral clock. A frequency query port returns the value for a small clock identifier, one cycle after the request.

The engine takes a 24 MHz reference. When the bypass bit is clear, it runs the PLL fractional formula through a shift-subtract divider. It then applies an optional 3/4 source scaling and two cascaded 1+N dividers. The IPG clock is half the AHB clock.

Top module: `clk_ctrl_regs`

## Requirements
- R1: After reset, the registers read back these values, by word index: 0 = 0x800B2C01, 1 = 0x84042800, 2 = 0xD0030000, 3 = 0x028A0100, 4 = 0x04008100, 5 = 0x00000438, 6 to 9 = 0x01010101, 22 = 0x00A00000, 23 and 24 = 0x0000A030, 25 = 0x43000000, all others 0. Out of reset, rvalid_o and q_valid_o are low.
- R2: A request at a byte address below 0x70 with address bits 1:0 zero is accepted. A write stores all 32 bits of wdata_i at word index addr_i>>2 with no masking. A read returns that word.
- R3: A request at address 0x70 or above, or with address bits 1:0 nonzero, gives err_o=1 and rdata_o=0. Such a write changes no register.
- R4: Every request is answered by rvalid_o exactly one cycle later. No response appears without a request.
- R5: The PLL output equals 24,000,000 when clock control bit 22 is set. Otherwise it equals floor(48,000,000 × (MFI'×(MFD+1)+MFN) / ((MFD+1)×(PD+1))), truncated to 32 bits. The fields come from the PLL control word: MFN = bits 9:0, MFI = bits 13:10, MFD = bits 25:16, PD = bits 29:26. MFI' is MFI raised to 5 when MFI is below 5.
- R6: The CPU clock is computed from the PLL output P. When clock control bit 14 is set, P is first replaced by floor(3P/4). The result is then divided, with truncation, by 1 + clock control bits 31:30.
- R7: The AHB clock is floor(CPU / (1 + clock control bits 29:28)). The IPG clock is floor(AHB/2).
- R8: With the reset values the frequencies are PLL 532,000,000, CPU 133,000,000, AHB 66,500,000 and IPG 33,250,000.
- R9: freq_valid_o falls within two cycles of an accepted write to word 0 or word 2. It rises again when the four frequencies reflect the new values. Writes to any other word leave freq_valid_o and the frequencies unchanged.
- R10: Query identifiers 1 and 2 return the IPG frequency. Identifier 3 returns 32768. Identifier 0 returns 0. Identifiers 4 to 7 return 0 with q_unsup_o=1. q_unsup_o is 0 for identifiers 0 to 3.
- R11: Every query request is answered by a q_valid_o pulse exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address inside the 4 KiB window |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Response strobe |
| rdata_o | output | 32 | Read data |
| err_o | output | 1 | Access error on this response |
| q_req_i | input | 1 | Frequency query request |
| q_id_i | input | 3 | Clock identifier |
| q_valid_o | output | 1 | Query result strobe |
| q_hz_o | output | 32 | Queried frequency in Hz |
| q_unsup_o | output | 1 | Identifier not supported |
| pll_hz_o | output | 32 | PLL output frequency |
| cpu_hz_o | output | 32 | CPU clock frequency |
| ahb_hz_o | output | 32 | AHB clock frequency |
| ipg_hz_o | output | 32 | IPG clock frequency |
| freq_valid_o | output | 1 | Frequencies are current |

## Verification
The ordering checks between the PLL, CPU, AHB and IPG values assume the PLL field values keep the product below 2^32. A wrapped PLL result would otherwise feed a smaller number downstream. The random configurations keep MFN at or below MFD so that the PLL stays under about 770 MHz. The stability check on the frequencies assumes the clock control and PLL words change only through bus writes. The bench issues one request at a time and lets each response be sampled before the next request.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;
  localparam int unsigned REG_NUM  = 28;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned REF_HZ   = 24_000_000;
  localparam int unsigned LOW_HZ   = 32_768;
  localparam int unsigned IDX_PLL  = 0;
  localparam int unsigned IDX_CTL  = 2;

  localparam int unsigned CC_ARMDIV = 30;
  localparam int unsigned CC_AHBDIV = 28;
  localparam int unsigned CC_BYPASS = 22;
  localparam int unsigned CC_ARMSRC = 14;

  localparam logic [2:0] QID_NONE   = 3'd0;
  localparam logic [2:0] QID_IPG    = 3'd1;
  localparam logic [2:0] QID_IPG_HI = 3'd2;
  localparam logic [2:0] QID_LOW    = 3'd3;

  function automatic logic [DATA_W-1:0] reset_val(input int unsigned idx);
    case (idx)
      0:        reset_val = 32'h800B_2C01;
      1:        reset_val = 32'h8404_2800;
      2:        reset_val = 32'hD003_0000;
      3:        reset_val = 32'h028A_0100;
      4:        reset_val = 32'h0400_8100;
      5:        reset_val = 32'h0000_0438;
      6, 7, 8, 9: reset_val = 32'h0101_0101;
      22:       reset_val = 32'h00A0_0000;
      23, 24:   reset_val = 32'h0000_A030;
      25:       reset_val = 32'h4300_0000;
      default:  reset_val = '0;
    endcase
  endfunction
endpackage

// File: rtl/clk_ctrl_regfile.sv
module clk_ctrl_regfile
  import clk_ctrl_pkg::*;
#(
  parameter int unsigned N_REGS = REG_NUM,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned DW     = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic [DW-1:0] pll_word_o,
  output logic [DW-1:0] ctl_word_o,
  output logic          cfg_wr_o
);
  localparam int unsigned IDX_W = $clog2(N_REGS);
  localparam int unsigned LIMIT = N_REGS * 4;

  logic [DW-1:0]    regs [N_REGS];
  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic             wr_en;
  logic [DW-1:0]    rd_word;

  assign in_win = (addr_i < AW'(LIMIT)) && (addr_i[1:0] == 2'b00);
  assign idx    = addr_i[IDX_W+1:2];
  assign wr_en  = req_i && we_i && in_win;
  assign cfg_wr_o = wr_en && ((idx == IDX_W'(IDX_PLL)) || (idx == IDX_W'(IDX_CTL)));

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs[g] <= reset_val(g);
      else if (wr_en && idx == IDX_W'(g))      regs[g] <= wdata_i;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_REGS; i++) begin
      if (idx == IDX_W'(i)) rd_word = regs[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      err_o    <= 1'b0;
    end else begin
      rvalid_o <= req_i;
      err_o    <= req_i && !in_win;
      rdata_o  <= (req_i && !we_i && in_win) ? rd_word : '0;
    end
  end

  assign pll_word_o = regs[IDX_PLL];
  assign ctl_word_o = regs[IDX_CTL];
endmodule

// File: rtl/clk_seq_div.sv
module clk_seq_div #(
  parameter int unsigned NUM_W = 64,
  parameter int unsigned DEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, quo_q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      den_q  <= den_i;
      quo_q  <= num_i;
      cnt_q  <= CNT_W'(NUM_W);
      busy_q <= 1'b1;
      done_o <= 1'b0;
    end else if (busy_q) begin
      rem_q  <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
      quo_q  <= {quo_q[NUM_W-2:0], fits};
      cnt_q  <= cnt_q - 1'b1;
      busy_q <= (cnt_q != CNT_W'(1));
      done_o <= (cnt_q == CNT_W'(1));
    end else begin
      done_o <= 1'b0;
    end
  end

  assign quo_o = quo_q;
endmodule

// File: rtl/clk_freq_engine.sv
module clk_freq_engine
  import clk_ctrl_pkg::*;
#(
  parameter int unsigned REF   = REF_HZ,
  parameter int unsigned NUM_W = 64,
  parameter int unsigned DEN_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] pll_word_i,
  input  logic [31:0] ctl_word_i,
  output logic [31:0] pll_hz_o,
  output logic [31:0] cpu_hz_o,
  output logic [31:0] ahb_hz_o,
  output logic [31:0] ipg_hz_o,
  output logic        valid_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_PLL, ST_CPU, ST_AHB} st_e;

  st_e              st_q;
  logic             src_q;
  logic [1:0]       armdiv_q, ahbdiv_q;
  logic             div_start, div_done;
  logic [NUM_W-1:0] div_num, div_quo;
  logic [DEN_W-1:0] div_den;

  logic [3:0]       mfi, mfi_eff;
  logic [9:0]       mfn;
  logic [10:0]      mfd1;
  logic [4:0]       pd1;
  logic [NUM_W-1:0] pll_num;
  logic [DEN_W-1:0] pll_den;

  function automatic logic [NUM_W-1:0] scale(input logic [NUM_W-1:0] x, input logic src);
    scale = src ? ((x * NUM_W'(3)) >> 2) : x;
  endfunction

  assign mfn     = pll_word_i[9:0];
  assign mfi     = pll_word_i[13:10];
  assign mfi_eff = (mfi < 4'd5) ? 4'd5 : mfi;
  assign mfd1    = {1'b0, pll_word_i[25:16]} + 11'd1;
  assign pd1     = {1'b0, pll_word_i[29:26]} + 5'd1;
  assign pll_num = NUM_W'(2 * REF) * (NUM_W'(mfi_eff) * NUM_W'(mfd1) + NUM_W'(mfn));
  assign pll_den = DEN_W'(mfd1) * DEN_W'(pd1);

  always_comb begin
    div_start = 1'b0;
    div_num   = '0;
    div_den   = '0;
    if (start_i) begin
      div_start = 1'b1;
      if (ctl_word_i[CC_BYPASS]) begin
        div_num = scale(NUM_W'(REF), ctl_word_i[CC_ARMSRC]);
        div_den = DEN_W'(ctl_word_i[CC_ARMDIV+:2]) + DEN_W'(1);
      end else begin
        div_num = pll_num;
        div_den = pll_den;
      end
    end else if (div_done && st_q == ST_PLL) begin
      div_start = 1'b1;
      div_num   = scale(NUM_W'(div_quo[31:0]), src_q);
      div_den   = DEN_W'(armdiv_q) + DEN_W'(1);
    end else if (div_done && st_q == ST_CPU) begin
      div_start = 1'b1;
      div_num   = NUM_W'(div_quo[31:0]);
      div_den   = DEN_W'(ahbdiv_q) + DEN_W'(1);
    end
  end

  clk_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (div_den),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      src_q    <= 1'b0;
      armdiv_q <= '0;
      ahbdiv_q <= '0;
      pll_hz_o <= '0;
      cpu_hz_o <= '0;
      ahb_hz_o <= '0;
      ipg_hz_o <= '0;
      valid_o  <= 1'b0;
    end else if (start_i) begin
      valid_o  <= 1'b0;
      src_q    <= ctl_word_i[CC_ARMSRC];
      armdiv_q <= ctl_word_i[CC_ARMDIV+:2];
      ahbdiv_q <= ctl_word_i[CC_AHBDIV+:2];
      if (ctl_word_i[CC_BYPASS]) begin
        pll_hz_o <= REF;
        st_q     <= ST_CPU;
      end else begin
        st_q     <= ST_PLL;
      end
    end else if (div_done) begin
      case (st_q)
        ST_PLL: begin
          pll_hz_o <= div_quo[31:0];
          st_q     <= ST_CPU;
        end
        ST_CPU: begin
          cpu_hz_o <= div_quo[31:0];
          st_q     <= ST_AHB;
        end
        ST_AHB: begin
          ahb_hz_o <= div_quo[31:0];
          ipg_hz_o <= div_quo[31:0] >> 1;
          valid_o  <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clk_freq_query.sv
module clk_freq_query
  import clk_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        q_req_i,
  input  logic [2:0]  q_id_i,
  input  logic [31:0] ipg_hz_i,
  output logic        q_valid_o,
  output logic [31:0] q_hz_o,
  output logic        q_unsup_o
);
  logic [31:0] hz_d;
  logic        unsup_d;

  always_comb begin
    hz_d    = '0;
    unsup_d = 1'b0;
    case (q_id_i)
      QID_NONE:            hz_d = '0;
      QID_IPG, QID_IPG_HI: hz_d = ipg_hz_i;
      QID_LOW:             hz_d = LOW_HZ;
      default:             unsup_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_valid_o <= 1'b0;
      q_hz_o    <= '0;
      q_unsup_o <= 1'b0;
    end else begin
      q_valid_o <= q_req_i;
      q_hz_o    <= q_req_i ? hz_d : '0;
      q_unsup_o <= q_req_i && unsup_d;
    end
  end
endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs
  import clk_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic        rvalid_o,
  output logic [31:0] rdata_o,
  output logic        err_o,
  input  logic        q_req_i,
  input  logic [2:0]  q_id_i,
  output logic        q_valid_o,
  output logic [31:0] q_hz_o,
  output logic        q_unsup_o,
  output logic [31:0] pll_hz_o,
  output logic [31:0] cpu_hz_o,
  output logic [31:0] ahb_hz_o,
  output logic [31:0] ipg_hz_o,
  output logic        freq_valid_o
);
  logic [31:0] pll_word, ctl_word;
  logic        cfg_wr;
  logic        kick_q;

  clk_ctrl_regfile #(.N_REGS(REG_NUM), .AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rvalid_o   (rvalid_o),
    .rdata_o    (rdata_o),
    .err_o      (err_o),
    .pll_word_o (pll_word),
    .ctl_word_o (ctl_word),
    .cfg_wr_o   (cfg_wr)
  );

  // recompute once after reset and after each clock-tree write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kick_q <= 1'b1;
    else         kick_q <= cfg_wr;
  end

  clk_freq_engine #(.REF(REF_HZ), .NUM_W(64), .DEN_W(16)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (kick_q),
    .pll_word_i (pll_word),
    .ctl_word_i (ctl_word),
    .pll_hz_o   (pll_hz_o),
    .cpu_hz_o   (cpu_hz_o),
    .ahb_hz_o   (ahb_hz_o),
    .ipg_hz_o   (ipg_hz_o),
    .valid_o    (freq_valid_o)
  );

  clk_freq_query u_query (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .q_req_i   (q_req_i),
    .q_id_i    (q_id_i),
    .ipg_hz_i  (ipg_hz_o),
    .q_valid_o (q_valid_o),
    .q_hz_o    (q_hz_o),
    .q_unsup_o (q_unsup_o)
  );
endmodule

// File: rtl/clk_ctrl_regs_chk.sv
module clk_ctrl_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        rvalid_o,
  input logic [31:0] rdata_o,
  input logic        err_o,
  input logic        q_req_i,
  input logic        q_valid_o,
  input logic [31:0] q_hz_o,
  input logic        q_unsup_o,
  input logic [31:0] pll_hz_o,
  input logic [31:0] cpu_hz_o,
  input logic [31:0] ahb_hz_o,
  input logic [31:0] ipg_hz_o,
  input logic        freq_valid_o
);
  assert_resp_follows_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rvalid_o);
  assert_no_spurious_resp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rvalid_o);
  assert_err_reads_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && err_o) |-> (rdata_o == 32'd0));
  assert_cpu_not_above_pll_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_valid_o |-> (cpu_hz_o <= pll_hz_o));
  assert_chain_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_valid_o |-> (ahb_hz_o <= cpu_hz_o && ipg_hz_o <= ahb_hz_o));
  assert_freq_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_valid_o && $past(freq_valid_o)) |-> ($stable(ipg_hz_o) && $stable(pll_hz_o)));
  assert_unsup_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_valid_o && q_unsup_o) |-> (q_hz_o == 32'd0));
  assert_query_resp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_req_i |=> q_valid_o);
  assert_query_no_spurious_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_req_i |=> !q_valid_o);
endmodule

bind clk_ctrl_regs clk_ctrl_regs_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .rvalid_o     (rvalid_o),
  .rdata_o      (rdata_o),
  .err_o        (err_o),
  .q_req_i      (q_req_i),
  .q_valid_o    (q_valid_o),
  .q_hz_o       (q_hz_o),
  .q_unsup_o    (q_unsup_o),
  .pll_hz_o     (pll_hz_o),
  .cpu_hz_o     (cpu_hz_o),
  .ahb_hz_o     (ahb_hz_o),
  .ipg_hz_o     (ipg_hz_o),
  .freq_valid_o (freq_valid_o)
);

// File: tb/clk_ctrl_regs_tb_top.sv
module clk_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        rvalid, err;
  logic [31:0] rdata;
  logic        q_req = 1'b0;
  logic [2:0]  q_id = '0;
  logic        q_valid, q_unsup;
  logic [31:0] q_hz, pll_hz, cpu_hz, ahb_hz, ipg_hz;
  logic        fvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] shadow [28];

  always #2 clk = ~clk;

  clk_ctrl_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata), .err_o(err),
    .q_req_i(q_req), .q_id_i(q_id), .q_valid_o(q_valid), .q_hz_o(q_hz), .q_unsup_o(q_unsup),
    .pll_hz_o(pll_hz), .cpu_hz_o(cpu_hz), .ahb_hz_o(ahb_hz), .ipg_hz_o(ipg_hz),
    .freq_valid_o(fvalid)
  );

  function automatic logic [31:0] exp_reset(int i);
    case (i)
      0: return 32'h800B2C01;   1: return 32'h84042800;   2: return 32'hD0030000;
      3: return 32'h028A0100;   4: return 32'h04008100;   5: return 32'h00000438;
      6, 7, 8, 9: return 32'h01010101;
      22: return 32'h00A00000;  23, 24: return 32'h0000A030; 25: return 32'h43000000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic longint unsigned m_pll(logic [31:0] mp, logic [31:0] cc);
    longint unsigned mfi, mfn, mfd, pd, num;
    if (cc[22]) return 24000000;
    mfn = longint'(mp[9:0]);
    mfi = longint'(mp[13:10]);
    if (mfi < 5) mfi = 5;
    mfd = longint'(mp[25:16]);
    pd  = longint'(mp[29:26]);
    num = 64'd48000000 * (mfi * (mfd + 1) + mfn);
    return (num / ((mfd + 1) * (pd + 1))) & 64'hFFFF_FFFF;
  endfunction

  function automatic longint unsigned m_cpu(longint unsigned p, logic [31:0] cc);
    longint unsigned x = p;
    if (cc[14]) x = (x * 3) / 4;
    return x / (longint'(cc[31:30]) + 1);
  endfunction

  function automatic longint unsigned m_ahb(longint unsigned c, logic [31:0] cc);
    return c / (longint'(cc[29:28]) + 1);
  endfunction

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R4 response strobe", rvalid, 1);
    rd = rdata; er = err;
    if (w && a < 12'h70 && a[1:0] == 2'b00) shadow[a >> 2] = d;
  endtask

  task automatic wait_freq();
    int n = 0;
    repeat (3) @(negedge clk);
    while (!fvalid && n < 3000) begin @(negedge clk); n++; end
    chk("R9 frequencies become valid", fvalid, 1);
  endtask

  task automatic check_freqs(input string tag, input logic [31:0] mp, input logic [31:0] cc);
    longint unsigned p, c, h;
    p = m_pll(mp, cc); c = m_cpu(p, cc); h = m_ahb(c, cc);
    chk({tag, " R5 pll"}, pll_hz, p);
    chk({tag, " R6 cpu"}, cpu_hz, c);
    chk({tag, " R7 ahb"}, ahb_hz, h);
    chk({tag, " R7 ipg"}, ipg_hz, h / 2);
  endtask

  task automatic query(input logic [2:0] id, input longint unsigned exp_hz, input logic exp_uns);
    @(negedge clk);
    q_req = 1'b1; q_id = id;
    @(negedge clk);
    q_req = 1'b0;
    chk("R11 query strobe", q_valid, 1);
    chk("R10 query value", q_hz, exp_hz);
    chk("R10 unsupported flag", q_unsup, exp_uns);
    @(negedge clk);
    chk("R11 single pulse", q_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] rd;
    logic er;
    void'($urandom(32'd7041));
    for (int i = 0; i < 28; i++) shadow[i] = exp_reset(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rvalid low after reset", rvalid, 0);
    chk("R1 q_valid low after reset", q_valid, 0);

    for (int i = 0; i < 28; i++) begin
      bus(1'b0, 12'(i * 4), 32'h0, rd, er);
      chk("R1 reset value", rd, exp_reset(i));
    end
    wait_freq();
    chk("R8 pll", pll_hz, 532000000);
    chk("R8 cpu", cpu_hz, 133000000);
    chk("R8 ahb", ahb_hz, 66500000);
    chk("R8 ipg", ipg_hz, 33250000);

    bus(1'b1, 12'h014, 32'hFFFF_FFFF, rd, er);
    chk("R2 write no error", er, 0);
    bus(1'b0, 12'h014, 32'h0, rd, er);
    chk("R2 full word stored", rd, 32'hFFFF_FFFF);
    bus(1'b1, 12'h06C, 32'hA5C3_0F96, rd, er);
    bus(1'b0, 12'h06C, 32'h0, rd, er);
    chk("R2 last word", rd, 32'hA5C3_0F96);

    bus(1'b0, 12'h070, 32'h0, rd, er);
    chk("R3 read beyond err", er, 1);
    chk("R3 read beyond data", rd, 0);
    bus(1'b1, 12'h080, 32'h1234_5678, rd, er);
    chk("R3 write beyond err", er, 1);
    bus(1'b1, 12'h001, 32'h1234_5678, rd, er);
    chk("R3 misaligned write err", er, 1);
    bus(1'b0, 12'h002, 32'h0, rd, er);
    chk("R3 misaligned read err", er, 1);
    chk("R3 misaligned read data", rd, 0);
    bus(1'b0, 12'h000, 32'h0, rd, er);
    chk("R3 word0 untouched", rd, 32'h800B2C01);
    chk("R3 freq still valid", fvalid, 1);
    bus(1'b0, 12'hFFC, 32'h0, rd, er);
    chk("R3 top of window err", er, 1);

    bus(1'b1, 12'h01C, 32'hDEAD_BEEF, rd, er);
    repeat (4) @(negedge clk);
    chk("R9 other write keeps valid", fvalid, 1);
    chk("R9 other write keeps ipg", ipg_hz, 33250000);

    bus(1'b1, 12'h008, 32'h5040_0000, rd, er);
    @(negedge clk);
    chk("R9 valid drops", fvalid, 0);
    wait_freq();
    check_freqs("bypass", shadow[0], shadow[2]);
    chk("R5 bypass pll ref", pll_hz, 24000000);

    bus(1'b1, 12'h008, 32'h1000_4000, rd, er);
    wait_freq();
    check_freqs("armsrc", shadow[0], shadow[2]);

    bus(1'b1, 12'h000, 32'h0000_0401, rd, er);
    wait_freq();
    check_freqs("mfi clamp", shadow[0], shadow[2]);

    query(3'd0, 0, 0);
    query(3'd1, ipg_hz, 0);
    query(3'd2, ipg_hz, 0);
    query(3'd3, 32768, 0);
    for (int id = 4; id < 8; id++) query(3'(id), 0, 1);

    for (int k = 0; k < 24; k++) begin
      logic [31:0] mp, cc;
      int unsigned mfd, mfn;
      mfd = $urandom % 1024;
      mfn = $urandom % (mfd + 1);
      mp = $urandom;
      mp[25:16] = 10'(mfd);
      mp[9:0]   = 10'(mfn);
      cc = $urandom;
      if (k % 4 == 0) cc[22] = 1'b0;
      bus(1'b1, 12'h000, mp, rd, er);
      bus(1'b1, 12'h008, cc, rd, er);
      wait_freq();
      check_freqs("random", mp, cc);
      query(3'(1 + (k % 2)), m_ahb(m_cpu(m_pll(mp, cc), cc), cc) / 2, 0);
    end

    for (int k = 0; k < 40; k++) begin
      logic [11:0] a;
      logic [31:0] d;
      logic ok;
      a = 12'(($urandom % 36) * 4);
      if (k % 7 == 3) a[1:0] = 2'(1 + $urandom % 3);
      d = $urandom;
      ok = (a < 12'h70) && (a[1:0] == 2'b00);
      bus(1'b1, a, d, rd, er);
      chk("R3 write error flag", er, !ok);
      bus(1'b0, {a[11:2], 2'b00}, 32'h0, rd, er);
      if (a < 12'h70) chk("R2 random readback", rd, shadow[a >> 2]);
      else chk("R3 random read zero", rd, 0);
    end

    report();
  end
endmodule